// File: doc/BRIEF.md
# Serial Transmit Bit-Clock Generator

This block creates the bit clock used by a synchronous serial transmitter. A programmable divider running on the master clock produces a divided clock with an exact 50% duty cycle. The receiver side uses the same divided clock, so it is also brought out on a port. A two-bit source field chooses what drives the transmit clock: the receiver clock, the divided clock, or an external clock taken from a pad. A separate bit can invert the chosen level.

The divide setting N is 12 bits wide. When N is zero the divider is idle. When N is 1 or more, each half period lasts N master cycles, so the ratio runs from 2 up to 8190. A new setting is picked up at the next half-period boundary, so the output never produces a shortened pulse.

The external pad clock passes through a synchronizer before it is selected. The transmit output leaves a register, so it cannot glitch. None of the pins carries a data stream. Every input is a plain control or clock level and is sampled on each master clock edge, with no handshake.

Top module: `txclk_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `div_clk_o` and `tx_clk_o` are both low.
- R2: A divide setting of zero keeps `div_clk_o` low and keeps the divider counter at zero.
- R3: For a setting N from 1 to 4095, every high phase and every low phase of `div_clk_o` lasts exactly N master clock cycles.
- R4: The largest setting, 4095, gives phases of 4095 cycles, which is a division by 8190.
- R5: A change to the setting in the middle of a phase does not shorten or stretch that phase. The new value applies from the next phase.
- R6: Writing zero while the divider runs finishes the current phase. After that, `div_clk_o` stays low.
- R7: `src_sel` encoding: 0 selects `rx_clk_in`, 1 selects `div_clk_o`, 2 selects the synchronized `ext_clk_in`, and 3 selects a constant low. For sources 0 and 1, `tx_clk_o` follows the chosen level one master clock cycle later.
- R8: A change on `ext_clk_in` reaches `tx_clk_o` exactly three master clock edges later (two synchronizer stages plus the output register).
- R9: With `inv_en` = 1, `tx_clk_o` is the complement of the selected level, including source 3, which then gives a constant high.
- R10: `src_sel` and `inv_en` have no effect on `div_clk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_set | input | 12 | Divide setting N (0 = divider off) |
| src_sel | input | 2 | Transmit clock source select |
| inv_en | input | 1 | Invert the selected transmit clock |
| rx_clk_in | input | 1 | Receiver clock level (master domain) |
| ext_clk_in | input | 1 | External clock from the pad (asynchronous) |
| div_clk_o | output | 1 | Divided clock, shared with the receiver |
| tx_clk_o | output | 1 | Final transmit clock |

## Verification
The divider is measured with several settings:
- N = 1, 2 and 3 separate the fastest case from the odd and even cases, and N = 4 and 5 add further odd/even pairs. These cases show whether duty stays exact for odd values.
- N = 4095 exposes a counter that is too narrow or a compare that wraps.

Setting changes are made in the middle of a phase, both to a smaller value and to zero. These cases show whether the update really waits for the phase boundary.

A table walks every source code with and without inversion. The receiver and pad levels are set opposite to each other, so picking the wrong source shows on the output. Single-step latency tests separate the one-register receiver path from the three-stage pad path.

// File: rtl/txclk_pkg.sv
package txclk_pkg;
  localparam int unsigned DIV_W  = 12;
  localparam int unsigned SYNC_N = 2;

  typedef enum logic [1:0] {
    SRC_RX   = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_NONE = 2'd3
  } src_e;
endpackage

// File: rtl/txclk_divider.sv
module txclk_divider #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_set,
  output logic         div_clk,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] act_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, act_q;
  logic         clk_q;
  logic         at_edge;

  // last count of the current half period
  assign at_edge = (cnt_q == act_q - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
      clk_q <= 1'b0;
    end else if (act_q == '0) begin
      // idle: hold low, pick up a setting whenever one appears
      cnt_q <= '0;
      clk_q <= 1'b0;
      act_q <= div_set;
    end else if (at_edge) begin
      cnt_q <= '0;
      act_q <= div_set;
      clk_q <= (div_set == '0) ? 1'b0 : ~clk_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign div_clk = clk_q;
  assign cnt_o   = cnt_q;
  assign act_o   = act_q;
endmodule

// File: rtl/txclk_sync.sv
module txclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[i] <= rst_n ? d : 1'b0;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= rst_n ? chain[i-1] : 1'b0;
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/txclk_select.sv
module txclk_select
  import txclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       inv_en,
  input  logic       rx_lvl,
  input  logic       div_lvl,
  input  logic       ext_lvl,
  output logic       tx_clk
);
  logic pick;
  logic tx_q;

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_RX:   pick = rx_lvl;
      SRC_DIV:  pick = div_lvl;
      SRC_EXT:  pick = ext_lvl;
      default:  pick = 1'b0;
    endcase
  end

  // registered output: one clean edge per master cycle at most
  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= pick ^ inv_en;
  end

  assign tx_clk = tx_q;
endmodule

// File: rtl/txclk_gen.sv
module txclk_gen
  import txclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_set,
  input  logic [1:0]       src_sel,
  input  logic             inv_en,
  input  logic             rx_clk_in,
  input  logic             ext_clk_in,
  output logic             div_clk_o,
  output logic             tx_clk_o
);
  logic [DIV_W-1:0] div_cnt, div_act;
  logic             ext_sync;

  txclk_divider #(.W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_set (div_set),
    .div_clk (div_clk_o),
    .cnt_o   (div_cnt),
    .act_o   (div_act)
  );

  txclk_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_clk_in),
    .q     (ext_sync)
  );

  txclk_select u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .inv_en  (inv_en),
    .rx_lvl  (rx_clk_in),
    .div_lvl (div_clk_o),
    .ext_lvl (ext_sync),
    .tx_clk  (tx_clk_o)
  );
endmodule

// File: rtl/txclk_gen_chk.sv
module txclk_gen_chk
  import txclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic             inv_en,
  input logic             rx_clk_in,
  input logic             div_clk_o,
  input logic             tx_clk_o,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_act
);
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act == '0) |-> (!div_clk_o && div_cnt == '0));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act != '0) |-> (div_cnt < div_act));

  assert_toggle_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act != '0 && div_cnt != div_act - DIV_W'(1)) |=> $stable(div_clk_o));

  assert_rx_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd0) |=> (tx_clk_o == $past(rx_clk_in ^ inv_en)));

  assert_div_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd1) |=> (tx_clk_o == $past(div_clk_o ^ inv_en)));

  assert_const_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |=> (tx_clk_o == $past(inv_en)));
endmodule

bind txclk_gen txclk_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_sel   (src_sel),
  .inv_en    (inv_en),
  .rx_clk_in (rx_clk_in),
  .div_clk_o (div_clk_o),
  .tx_clk_o  (tx_clk_o),
  .div_cnt   (div_cnt),
  .div_act   (div_act)
);

// File: tb/sim_txclk_gen.sv
`timescale 1ns/1ps
module sim_txclk_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] div_set;
  logic [1:0]  src_sel;
  logic        inv_en, rx_clk_in, ext_clk_in;
  logic        div_clk_o, tx_clk_o;

  int n_run = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  txclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_set(div_set), .src_sel(src_sel),
    .inv_en(inv_en), .rx_clk_in(rx_clk_in), .ext_clk_in(ext_clk_in),
    .div_clk_o(div_clk_o), .tx_clk_o(tx_clk_o)
  );

  // {src_sel, inv_en, rx, ext, expected tx}
  typedef logic [5:0] vec_t;
  localparam vec_t VECS [8] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_n(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 20000 && div_clk_o !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 20000 && div_clk_o !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic count_level(input logic lvl, output int c);
    c = 0;
    for (int i = 0; i < 20000 && div_clk_o === lvl; i++) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int n, input string req);
    int hi, lo;
    div_set = 12'(n);
    wait_rise();
    count_level(1'b1, hi);
    count_level(1'b0, lo);
    check_n({req, " high"}, hi, n);
    check_n({req, " low"},  lo, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    logic seen;
    rst_n = 1'b0; div_set = 12'd3; src_sel = 2'd0; inv_en = 1'b1;
    rx_clk_in = 1'b1; ext_clk_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 div reset", div_clk_o, 1'b0);
    check("R1 tx reset",  tx_clk_o,  1'b0);
    rst_n = 1'b1;
    div_set = 12'd0; inv_en = 1'b0; rx_clk_in = 1'b0; ext_clk_in = 1'b0;
    @(negedge clk);
    check("R1 div after reset", div_clk_o, 1'b0);

    // R7 R9 source table with divider idle (divided clock low)
    for (int k = 0; k < 8; k++) begin
      {src_sel, inv_en, rx_clk_in, ext_clk_in} = VECS[k][5:1];
      repeat (4) @(negedge clk);
      check($sformatf("R7/R9 vec %0d", k), tx_clk_o, VECS[k][0]);
    end

    // R2 zero setting keeps divider idle; R10 select/invert toggling
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      src_sel = 2'(i % 4); inv_en = i[0];
      @(negedge clk);
      seen |= div_clk_o;
    end
    check("R2/R10 idle low", seen, 1'b0);

    // R3 odd and even settings
    src_sel = 2'd1; inv_en = 1'b0;
    measure(1, "R3 N=1");
    measure(2, "R3 N=2");
    measure(3, "R3 N=3");
    measure(4, "R3 N=4");
    measure(5, "R3 N=5");

    // R10 divider unaffected by select/invert
    src_sel = 2'd2; inv_en = 1'b1;
    measure(3, "R10 N=3 other src");

    // R4 maximum setting
    measure(4095, "R4 N=4095");

    // R5 change mid-phase
    measure(5, "R5 prep");
    wait_rise();
    div_set = 12'd2;
    count_level(1'b1, hi);
    count_level(1'b0, lo);
    check_n("R5 old phase kept", hi, 5);
    check_n("R5 new phase", lo, 2);

    // R6 write zero while running
    measure(3, "R6 prep");
    wait_rise();
    div_set = 12'd0;
    count_level(1'b1, hi);
    check_n("R6 phase finished", hi, 3);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      seen |= div_clk_o;
      @(negedge clk);
    end
    check("R6 stays low", seen, 1'b0);

    // R7 receiver latency: one edge
    src_sel = 2'd0; inv_en = 1'b0; rx_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    rx_clk_in = 1'b1;
    @(negedge clk);
    check("R7 rx one-cycle latency", tx_clk_o, 1'b1);

    // R8 external latency: three edges
    src_sel = 2'd2; ext_clk_in = 1'b0;
    repeat (5) @(negedge clk);
    ext_clk_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 ext not yet", tx_clk_o, 1'b0);
    @(negedge clk);
    check("R8 ext after three", tx_clk_o, 1'b1);

    // R9 invert on divided source
    src_sel = 2'd1; inv_en = 1'b1; div_set = 12'd0;
    repeat (10) @(negedge clk);
    check("R9 inverted idle div", tx_clk_o, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule